// File: doc/BRIEF.md
# Skip Predicate Instruction Suppressor

This block keeps one skip predicate for an issue stage and uses it to cancel single instructions without a branch. A skip-set request carries two condition bits and a 3-bit function code. The block evaluates the function on the two bits and stores the one-bit result, together with a flag that marks the predicate as in force. Every later instruction that carries a skip flag is cancelled while the stored predicate is true. Instructions without the flag always run.

The predicate stays in force over any number of instructions. A new skip-set request replaces it. A stop-skipping event, raised by the exit variant that ends skipping, removes it. The suppress output is combinational from the issue inputs and the stored state, so it is valid in the same cycle the instruction issues and can gate that instruction's write-back directly. The reset input is asynchronous and active-low, and the block releases it synchronously inside.

Top module: `skip_suppressor`

## Requirements
- R1: After reset, and before any skip-set request, no instruction is suppressed, whether or not it carries a skip flag.
- R2: A skip-set request (`set_vld`=1) evaluates `set_func` on A=`cond_a` and B=`cond_b` with this encoding: 0 A AND B, 1 A OR B, 2 A XOR B, 3 A XNOR B, 4 A NAND B, 5 A NOR B, 6 A AND NOT B, 7 A OR NOT B. The result is the new predicate.
- R3: An issuing instruction (`issue_vld`=1) with `issue_skip`=1 raises `suppress` when the stored predicate is in force and true. When the predicate is false, `suppress` stays low.
- R4: An issuing instruction with `issue_skip`=0 never raises `suppress`.
- R5: A stored predicate stays unchanged over any number of instructions until the next skip-set or stop event. Changes on `cond_a`, `cond_b` and `set_func` without `set_vld` have no effect.
- R6: A new skip-set request fully replaces the previous predicate.
- R7: `stop_skip`=1 (without `set_vld`) removes the predicate. From the next cycle on, nothing is suppressed until the next skip-set request.
- R8: When `set_vld` and `stop_skip` are high in the same cycle, the skip-set request wins and its predicate is in force from the next cycle.
- R9: `suppress` is combinational in the issue cycle. An instruction issued in the same cycle as a skip-set or stop event still sees the old state. `suppress` is low whenever `issue_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_vld | input | 1 | Skip-set request |
| set_func | input | 3 | Two-input function code for the predicate |
| cond_a | input | 1 | First condition bit (A) |
| cond_b | input | 1 | Second condition bit (B) |
| stop_skip | input | 1 | Exit variant that ends skipping |
| issue_vld | input | 1 | An instruction issues this cycle |
| issue_skip | input | 1 | Skip flag of the issuing instruction |
| suppress | output | 1 | Cancel the result of the issuing instruction |

## Verification
The block's internal state is only the in-force flag and the predicate bit. Both show up at `suppress` on the first flagged instruction after the state goes wrong. A wrong function evaluation or a lost hold would make one flagged issue come out inverted in the cycle right after the skip-set. A stuck in-force flag would keep cancelling flagged instructions after a stop event. Because of this, the bench follows every state-changing event with a flagged issue in the very next cycle. It also checks issues placed in the same cycle as a set or stop, which exposes any path that bypasses the register.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_AND   = 3'd0,
    FN_OR    = 3'd1,
    FN_XOR   = 3'd2,
    FN_XNOR  = 3'd3,
    FN_NAND  = 3'd4,
    FN_NOR   = 3'd5,
    FN_ANDN  = 3'd6,
    FN_ORN   = 3'd7
  } skip_func_e;

  typedef struct packed {
    logic armed;
    logic value;
  } skip_state_t;
endpackage

// File: rtl/skip_rst_sync.sv
module skip_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/skip_func_eval.sv
module skip_func_eval
  import skip_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  input  logic              a,
  input  logic              b,
  output logic              result
);
  always_comb begin
    unique case (skip_func_e'(func))
      FN_AND:  result = a & b;
      FN_OR:   result = a | b;
      FN_XOR:  result = a ^ b;
      FN_XNOR: result = ~(a ^ b);
      FN_NAND: result = ~(a & b);
      FN_NOR:  result = ~(a | b);
      FN_ANDN: result = a & ~b;
      FN_ORN:  result = a | ~b;
      default: result = 1'b0;
    endcase
  end
endmodule

// File: rtl/skip_pred_reg.sv
module skip_pred_reg
  import skip_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_i,
  input  logic        stop_i,
  input  logic        eval_i,
  output skip_state_t state_o
);
  skip_state_t state_q, state_d;
  logic        upd_en;

  assign upd_en = set_i | stop_i;

  always_comb begin
    state_d = state_q;
    if (set_i) begin
      state_d.armed = 1'b1;
      state_d.value = eval_i;
    end else if (stop_i) begin
      state_d.armed = 1'b0;
      state_d.value = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= '0;
    else if (upd_en) state_q <= state_d;
  end

  assign state_o = state_q;

  assert_set_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (state_q.armed && state_q.value == $past(eval_i)));

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !set_i) |=> !state_q.armed);

  assert_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !stop_i) |=> $stable(state_q));
endmodule

// File: rtl/skip_suppressor.sv
module skip_suppressor
  import skip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic [FUNC_W-1:0] set_func,
  input  logic              cond_a,
  input  logic              cond_b,
  input  logic              stop_skip,
  input  logic              issue_vld,
  input  logic              issue_skip,
  output logic              suppress
);
  logic        rst_int_n;
  logic        eval_bit;
  skip_state_t pred;

  skip_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  skip_func_eval u_eval (
    .func   (set_func),
    .a      (cond_a),
    .b      (cond_b),
    .result (eval_bit)
  );

  skip_pred_reg u_pred (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_i   (set_vld),
    .stop_i  (stop_skip),
    .eval_i  (eval_bit),
    .state_o (pred)
  );

  assign suppress = issue_vld & issue_skip & pred.armed & pred.value;

  assert_unflagged_runs_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (issue_vld && !issue_skip) |-> !suppress);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !issue_vld |-> !suppress);

  assert_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(stop_skip) && !$past(set_vld)) |-> !suppress);

  assert_false_runs_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(set_vld) && !$past(eval_bit)) |-> !suppress);
endmodule

// File: tb/skip_suppressor_tb.sv
module skip_suppressor_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       set_vld, cond_a, cond_b, stop_skip, issue_vld, issue_skip;
  logic [2:0] set_func;
  logic       suppress;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  bit m_armed = 1'b0;
  bit m_value = 1'b0;

  always #10 clk = ~clk;

  skip_suppressor u_dut (
    .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .set_func(set_func),
    .cond_a(cond_a), .cond_b(cond_b), .stop_skip(stop_skip),
    .issue_vld(issue_vld), .issue_skip(issue_skip), .suppress(suppress)
  );

  function automatic bit ref_fn(input int f, input bit a, input bit b);
    case (f)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return ~(a ^ b);
      4: return ~(a & b);
      5: return ~(a | b);
      6: return a & ~b;
      default: return a | ~b;
    endcase
  endfunction

  task automatic step(input bit s, input int f, input bit a, input bit b,
                      input bit st, input bit iv, input bit sk, input string tag);
    @(negedge clk);
    set_vld    = s;
    set_func   = 3'(s ? f : $urandom_range(7));
    cond_a     = s ? a : 1'($urandom_range(1));
    cond_b     = s ? b : 1'($urandom_range(1));
    stop_skip  = st;
    issue_vld  = iv;
    issue_skip = sk;
    exp_q.push_back(iv & sk & m_armed & m_value);
    tag_q.push_back(tag);
    if (s) begin
      m_armed = 1'b1;
      m_value = ref_fn(f, a, b);
    end else if (st) begin
      m_armed = 1'b0;
      m_value = 1'b0;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (suppress !== e) begin
          fails++;
          $display("FAIL %s: suppress=%b expected=%b at %0t", t, suppress, e, $time);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    set_vld = 0; set_func = 0; cond_a = 0; cond_b = 0;
    stop_skip = 0; issue_vld = 0; issue_skip = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: flagged and unflagged issues before any set
    step(0, 0, 0, 0, 0, 1, 1, "R1");
    step(0, 0, 0, 0, 0, 1, 0, "R1");

    // R2 / R3 / R4: every function on every input pair
    for (int f = 0; f < 8; f++) begin
      for (int ab = 0; ab < 4; ab++) begin
        step(1, f, ab[1], ab[0], 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 1, 1, "R3");
        step(0, 0, 0, 0, 0, 1, 0, "R4");
      end
    end

    // R5: a true predicate holds over many issues with wandering conditions
    step(1, 0, 1, 1, 0, 0, 0, "R5");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 1, "R5");
    step(0, 0, 0, 0, 0, 1, 0, "R5");
    step(0, 0, 0, 0, 0, 1, 1, "R5");

    // R6: replacement true -> false -> true
    step(1, 1, 1, 0, 0, 0, 0, "R6");
    step(1, 2, 1, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 1, "R6");
    step(1, 5, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 1, "R6");

    // R7: stop removes a true predicate for several issues
    step(0, 0, 0, 0, 1, 0, 0, "R7");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 1, "R7");

    // R8: set and stop together, set wins
    step(1, 3, 0, 0, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 1, "R8");

    // R9: same-cycle issue sees old state; idle issue stays quiet
    step(0, 0, 0, 0, 0, 0, 1, "R9");
    step(1, 0, 0, 1, 0, 1, 1, "R9");
    step(0, 0, 0, 0, 0, 1, 1, "R9");
    step(1, 1, 1, 1, 0, 1, 1, "R9");
    step(0, 0, 0, 0, 1, 1, 1, "R9");
    step(0, 0, 0, 0, 0, 1, 1, "R9");

    step(0, 0, 0, 0, 0, 0, 0, "R9");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule